// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask

The block collects interrupt requests from four kinds of source and decides which one the CPU should take next. The sources are a non-maskable line, a debug-break line, a group of external request lines and a group of on-chip peripheral request lines. The non-maskable and break sources have fixed levels of 16 and 15. Every external and peripheral source has a 4-bit level that software programs through a small register file. Each cycle the block finds the highest-level pending source and compares its level with the CPU's current 4-bit mask. If the request is accepted, the block presents a request flag, the source's vector number and the mask value the CPU must load.

Request lines are level-sensitive. A high line sets a pending flag that stays set until the CPU acknowledges that source. The outputs are recomputed from the pending state and the mask every cycle. A more urgent request that arrives before the acknowledge therefore replaces the one being presented. Stacking the CPU state and fetching the vector table are left to the CPU.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every programmable level is 0, no source is pending, irq_req_o is low and every register reads 0.
- R2: Programmable sources are numbered with the external lines first (0..N_EXT-1), then the peripheral lines. Source k has its 4-bit level in register k/4, at bits [4*(k%4)+3 : 4*(k%4)]. A write with reg_we_i high stores reg_wdata_i, and reg_rdata_o returns the stored register for reg_addr_i in the same cycle. Fields with no source behind them read 0.
- R3: Vector numbers are: 0 for the non-maskable source, 1 for the break source, 2+e for external line e and 2+N_EXT+p for peripheral line p.
- R4: The non-maskable source has level 16 and is accepted whatever the value of cpu_mask_i. While it is presented, irq_mask_o is 4'hF.
- R5: A maskable source is accepted only if its level is strictly greater than cpu_mask_i. On acceptance irq_mask_o equals that level.
- R6: The break source has fixed level 15. It is therefore blocked by a mask of 15.
- R7: A programmable source at level 0 is disabled and is never presented.
- R8: The presented source is the pending source with the highest level. Among equal levels, the lowest vector number wins.
- R9: A request line that is high at a clock edge makes its source pending from that edge on. The source stays pending after the line falls.
- R10: An ack_i pulse while irq_req_o is high clears the pending flag of the presented source. If that source's line is still high, it stays pending. An ack_i pulse while irq_req_o is low changes nothing.
- R11: irq_req_o, irq_vec_o and irq_mask_o follow the pending state and the current cpu_mask_i in the same cycle. A more urgent source that becomes pending before the acknowledge replaces the one being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request line |
| brk_i | input | 1 | Debug-break request line |
| ext_req_i | input | N_EXT | External request lines |
| per_req_i | input | N_PER | On-chip peripheral request lines |
| reg_we_i | input | 1 | Level register write enable |
| reg_addr_i | input | ADDR_W | Level register index |
| reg_wdata_i | input | 16 | Level register write data |
| reg_rdata_o | output | 16 | Level register read data |
| cpu_mask_i | input | 4 | Current CPU interrupt mask |
| irq_req_o | output | 1 | Accepted interrupt presented |
| irq_vec_o | output | VEC_W | Vector number of the presented source |
| irq_mask_o | output | 4 | Mask value the CPU loads on acceptance |
| ack_i | input | 1 | CPU acknowledge pulse |

## Verification
The assertions check the following on every cycle: a presented maskable source is always above the CPU mask, the non-maskable and break sources always load a mask of 15, no presented mask is 0, and the vector stays within range. They also check that a high non-maskable line is presented at the next edge. Only the bench scenarios can show that a tie is resolved in index order and that a more urgent arrival replaces the presented vector. The same holds for pending flags surviving a dropped line or an acknowledge given while nothing is presented, and for register fields landing in the right sources. The bench checks these against a behavioural model on every cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned ARB_W  = LVL_W + 1;  // one extra bit for level 16
  localparam int unsigned REG_W  = 16;
  localparam int unsigned FLD_N  = REG_W / LVL_W;
  localparam int unsigned NMI_IX = 0;
  localparam int unsigned BRK_IX = 1;
  localparam int unsigned FIX_N  = 2;

  typedef logic [ARB_W-1:0] arb_lvl_t;

  localparam arb_lvl_t LVL_NMI = arb_lvl_t'(16);
  localparam arb_lvl_t LVL_BRK = arb_lvl_t'(15);
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_PROG = 16,
  parameter int unsigned N_REG  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic [N_PROG*LVL_W-1:0] lvl_o
);
  localparam int unsigned N_FLD = N_REG * FLD_N;

  logic [N_FLD*LVL_W-1:0] fld_q;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    localparam int unsigned RI = f / FLD_N;
    localparam int unsigned FI = f % FLD_N;
    if (f < N_PROG) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          fld_q[f*LVL_W +: LVL_W] <= '0;
        end else if (we_i && (addr_i == ADDR_W'(RI))) begin
          fld_q[f*LVL_W +: LVL_W] <= wdata_i[FI*LVL_W +: LVL_W];
        end
      end
    end else begin : g_pad
      assign fld_q[f*LVL_W +: LVL_W] = '0;
    end
  end

  assign lvl_o = fld_q[N_PROG*LVL_W-1:0];

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (addr_i == ADDR_W'(r)) rdata_o = fld_q[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned N_SRC = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  // set beats clear: a line still held high stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 18,
  parameter int unsigned VEC_W = 5
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*ARB_W-1:0] lvl_i,
  output logic                   vld_o,
  output logic [VEC_W-1:0]       idx_o,
  output arb_lvl_t               lvl_o
);
  // scan downwards with >= so the lowest index wins a tie
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (lvl_i[i*ARB_W +: ARB_W] != '0) &&
          (lvl_i[i*ARB_W +: ARB_W] >= lvl_o)) begin
        vld_o = 1'b1;
        idx_o = VEC_W'(i);
        lvl_o = lvl_i[i*ARB_W +: ARB_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned N_PER  = 8,
  localparam int unsigned N_PROG = N_EXT + N_PER,
  localparam int unsigned N_SRC  = N_PROG + FIX_N,
  localparam int unsigned N_REG  = (N_PROG + FLD_N - 1) / FLD_N,
  localparam int unsigned ADDR_W = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int unsigned VEC_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              brk_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_PER-1:0]  per_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [3:0]        cpu_mask_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [3:0]        irq_mask_o,
  input  logic              ack_i
);
  logic [N_PROG*LVL_W-1:0] prog_lvl;
  logic [N_SRC*ARB_W-1:0]  src_lvl;
  logic [N_SRC-1:0]        src_set;
  logic [N_SRC-1:0]        src_clr;
  logic [N_SRC-1:0]        pend;
  logic                    win_vld;
  logic [VEC_W-1:0]        win_idx;
  arb_lvl_t                win_lvl;
  logic                    win_nmi;
  logic                    accept;

  irq_lvl_regs #(
    .N_PROG (N_PROG),
    .N_REG  (N_REG),
    .ADDR_W (ADDR_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .lvl_o   (prog_lvl)
  );

  assign src_set = {per_req_i, ext_req_i, brk_i, nmi_i};

  assign src_lvl[NMI_IX*ARB_W +: ARB_W] = LVL_NMI;
  assign src_lvl[BRK_IX*ARB_W +: ARB_W] = LVL_BRK;
  for (genvar k = 0; k < N_PROG; k++) begin : g_lvl
    assign src_lvl[(k+FIX_N)*ARB_W +: ARB_W] = {1'b0, prog_lvl[k*LVL_W +: LVL_W]};
  end

  irq_pend #(
    .N_SRC (N_SRC)
  ) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .pend_o (pend)
  );

  irq_arb #(
    .N_SRC (N_SRC),
    .VEC_W (VEC_W)
  ) i_arb (
    .pend_i (pend),
    .lvl_i  (src_lvl),
    .vld_o  (win_vld),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  assign win_nmi = (win_lvl == LVL_NMI);
  assign accept  = win_vld && (win_nmi || (win_lvl > {1'b0, cpu_mask_i}));

  always_comb begin
    src_clr = '0;
    if (accept && ack_i) src_clr[win_idx] = 1'b1;
  end

  assign irq_req_o  = accept;
  assign irq_vec_o  = win_idx;
  assign irq_mask_o = win_nmi ? 4'hF : win_lvl[LVL_W-1:0];
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned N_PER  = 8,
  localparam int unsigned N_SRC = N_EXT + N_PER + 2,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nmi_i,
  input logic [3:0]       cpu_mask_i,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [3:0]       irq_mask_o
);
  AST_NMI_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> (irq_req_o && irq_vec_o == '0));  // R4

  AST_NMI_MASK_F: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_vec_o == '0) |-> (irq_mask_o == 4'hF));  // R4

  AST_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_vec_o != '0) |-> (irq_mask_o > cpu_mask_i));  // R5

  AST_BRK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_vec_o == VEC_W'(1)) |-> (irq_mask_o == 4'hF));  // R6

  AST_NO_ZERO_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_mask_o != 4'h0));  // R7

  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o < VEC_W'(N_SRC)));  // R3
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_EXT (N_EXT),
  .N_PER (N_PER)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nmi_i      (nmi_i),
  .cpu_mask_i (cpu_mask_i),
  .irq_req_o  (irq_req_o),
  .irq_vec_o  (irq_vec_o),
  .irq_mask_o (irq_mask_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXT  = 8;
  localparam int N_PER  = 8;
  localparam int N_PROG = N_EXT + N_PER;
  localparam int N_SRC  = N_PROG + 2;
  localparam int N_REG  = (N_PROG + 3) / 4;
  localparam int ADDR_W = 2;
  localparam int VEC_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 1'b0, brk = 1'b0, we = 1'b0, ack = 1'b0;
  logic [N_EXT-1:0] ext = '0;
  logic [N_PER-1:0] per = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0] mask = '0;
  logic req;
  logic [VEC_W-1:0] vec;
  logic [3:0] nmask;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  int lvl_m[N_PROG];
  bit pend_m[N_SRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.N_EXT(N_EXT), .N_PER(N_PER)) i_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .brk_i(brk),
    .ext_req_i(ext), .per_req_i(per), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cpu_mask_i(mask),
    .irq_req_o(req), .irq_vec_o(vec), .irq_mask_o(nmask), .ack_i(ack)
  );

  function automatic int src_level(int s);
    if (s == 0) return 16;
    if (s == 1) return 15;
    return lvl_m[s-2];
  endfunction

  function automatic void model_eval(output bit m_req, output int m_vec, output int m_mask);
    int best = -1;
    int bl = 0;
    for (int s = 0; s < N_SRC; s++) begin
      if (pend_m[s] && src_level(s) > bl) begin
        best = s;
        bl = src_level(s);
      end
    end
    m_req  = (best >= 0) && (bl == 16 || bl > int'(mask));
    m_vec  = (best < 0) ? 0 : best;
    m_mask = (bl == 16) ? 15 : bl;
  endfunction

  function automatic int model_reg(int a);
    int v = 0;
    for (int j = 0; j < 4; j++) begin
      if (a*4 + j < N_PROG) v = v | (lvl_m[a*4+j] << (4*j));
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_PROG; k++) lvl_m[k] = 0;
      for (int s = 0; s < N_SRC; s++) pend_m[s] = 1'b0;
    end else begin
      bit r; int v; int m;
      model_eval(r, v, m);
      if (ack && r) pend_m[v] = 1'b0;
      if (nmi) pend_m[0] = 1'b1;
      if (brk) pend_m[1] = 1'b1;
      for (int e = 0; e < N_EXT; e++) if (ext[e]) pend_m[2+e] = 1'b1;
      for (int p = 0; p < N_PER; p++) if (per[p]) pend_m[2+N_EXT+p] = 1'b1;
      if (we) begin
        for (int j = 0; j < 4; j++) begin
          if (int'(addr)*4 + j < N_PROG) lvl_m[int'(addr)*4+j] = (int'(wdata) >> (4*j)) & 15;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit r; int v; int m;
      model_eval(r, v, m);
      n_chk++;
      if (req !== r) begin
        n_fail++;
        $display("FAIL R11 irq_req_o act=%0d exp=%0d", req, r);
      end else if (r && (int'(vec) != v || int'(nmask) != m)) begin
        n_fail++;
        $display("FAIL R8 vec/mask act=%0d/%0d exp=%0d/%0d", vec, nmask, v, m);
      end
      n_chk++;
      if (int'(rdata) != model_reg(int'(addr))) begin
        n_fail++;
        $display("FAIL R2 reg_rdata_o act=%h exp=%h", rdata, model_reg(int'(addr)));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_irq(bit r, int v, int m, string tag);
    @(negedge clk);
    #1;
    n_chk++;
    if (req !== r || (r && (int'(vec) != v || int'(nmask) != m))) begin
      n_fail++;
      $display("FAIL %s req/vec/mask act=%0d/%0d/%0d exp=%0d/%0d/%0d", tag, req, vec, nmask, r, v, m);
    end
  endtask

  task automatic wr(int a, int d);
    tick();
    we = 1'b1; addr = ADDR_W'(a); wdata = 16'(d);
    tick();
    we = 1'b0;
  endtask

  task automatic rd_check(int a, int d, string tag);
    tick();
    addr = ADDR_W'(a);
    @(negedge clk);
    #1;
    n_chk++;
    if (int'(rdata) != d) begin
      n_fail++;
      $display("FAIL %s reg %0d act=%h exp=%h", tag, a, rdata, d);
    end
  endtask

  task automatic pulse_ack();
    tick(); ack = 1'b1;
    tick(); ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_irq(0, 0, 0, "R1");
    for (int a = 0; a < N_REG; a++) rd_check(a, 0, "R1");

    // R2 register layout and readback
    wr(0, 16'h4321);   // ext0..3 = 1,2,3,4
    wr(1, 16'h0765);   // ext4..7 = 5,6,7,0
    wr(2, 16'hA9B8);   // per0..3 = 8,B,9,A
    wr(3, 16'hF0C5);   // per4..7 = 5,C,0,F
    rd_check(0, 16'h4321, "R2");
    rd_check(1, 16'h0765, "R2");
    rd_check(2, 16'hA9B8, "R2");
    rd_check(3, 16'hF0C5, "R2");

    // R9 latch survives a one-cycle pulse; R3 vector 2+e; R5 mask = level
    tick(); ext[1] = 1'b1;
    tick(); ext[1] = 1'b0;
    expect_irq(1, 3, 2, "R9");
    expect_irq(1, 3, 2, "R3");
    pulse_ack();
    expect_irq(0, 0, 0, "R10");

    // R7 level 0 source never presented
    tick(); ext[7] = 1'b1;
    tick(); ext[7] = 1'b0;
    expect_irq(0, 0, 0, "R7");
    expect_irq(0, 0, 0, "R7");

    // R5 strict comparison against the mask
    tick(); mask = 4'd4; ext[3] = 1'b1;
    tick(); ext[3] = 1'b0;
    expect_irq(0, 0, 0, "R5");
    tick(); mask = 4'd3;
    expect_irq(1, 5, 4, "R5");
    // R10 ack with nothing presented changes nothing
    tick(); mask = 4'd15;
    expect_irq(0, 0, 0, "R5");
    pulse_ack();
    tick(); mask = 4'd0;
    expect_irq(1, 5, 4, "R10");
    pulse_ack();
    expect_irq(0, 0, 0, "R10");

    // R8 tie at level 8: ext0 (vec 2) beats per0 (vec 10)
    wr(0, 16'h4328);
    tick(); ext[0] = 1'b1; per[0] = 1'b1;
    tick(); ext[0] = 1'b0; per[0] = 1'b0;
    expect_irq(1, 2, 8, "R8");
    pulse_ack();
    expect_irq(1, 10, 8, "R8");
    pulse_ack();
    expect_irq(0, 0, 0, "R10");

    // R11 higher arrival replaces presented vector before ack
    tick(); ext[5] = 1'b1;
    tick(); ext[5] = 1'b0;
    expect_irq(1, 7, 6, "R11");
    tick(); per[7] = 1'b1;
    tick(); per[7] = 1'b0;
    expect_irq(1, 17, 15, "R11");
    // R6 break at 15 ties with per7 and wins on index
    tick(); brk = 1'b1;
    tick(); brk = 1'b0;
    expect_irq(1, 1, 15, "R6");
    // R6 mask 15 blocks the break source
    tick(); mask = 4'd15;
    expect_irq(0, 0, 0, "R6");
    tick(); mask = 4'd0;
    pulse_ack();
    expect_irq(1, 17, 15, "R8");
    pulse_ack();
    expect_irq(1, 7, 6, "R8");
    pulse_ack();
    expect_irq(0, 0, 0, "R10");

    // R4 NMI under full mask; R10 held line stays pending through ack
    tick(); mask = 4'd15; nmi = 1'b1;
    tick();
    expect_irq(1, 0, 15, "R4");
    pulse_ack();
    expect_irq(1, 0, 15, "R10");
    tick(); nmi = 1'b0;
    pulse_ack();
    expect_irq(0, 0, 0, "R4");

    repeat (3) tick();
    finish_run();
  end
endmodule